// File: doc/BRIEF.md
# Converter Serial Port Model

This block models the digital serial port on the device side of a delta-sigma converter, with the serial clock supplied by the host. A timer that counts system clocks takes the place of the analog core. When the count ends, the block captures a parallel result and a sign flag into a 24-bit output frame. It then waits in a sleep state until the host selects it.

Selection is by an active-low chip select. While the host holds the chip select low and no data phase is active, the data output acts as a status flag: high while a conversion is running, low once a result is waiting. Pulling chip select low in the sleep state opens the data phase. The frame is shifted out MSB first and moves one bit on each falling edge of the serial clock. On the rising edges, channel-select bits are taken in from the data input.

The host can end the data phase in three ways. Clocking out the whole frame starts the next conversion and latches the channel bits. Releasing chip select part-way through drops the frame and its channel bits and starts a new conversion. Releasing chip select before any rising clock edge leaves the result waiting. Chip select, serial clock and data input all pass through two-flop synchronisers into the system clock domain, and their edges are detected there.

Top module: `adc_serial_port`

## Requirements
- R1: `sdo_oe_o` is low within 3 system clocks after `cs_ni` goes high, and high within 3 clocks after it goes low. After reset `chan_o` is 0 and a conversion is running.
- R2: While a conversion runs and chip select is low, `sdo_o` is 1.
- R3: A conversion lasts `CONV_CYCLES` system clocks (the first one starts at reset release). At its end, `sign_i` and `result_i` are captured. Changes to them after that point do not alter the frame. In the sleep state with chip select low, `sdo_o` is 0.
- R4: Frame bits, first to last: 0 (end-of-conversion flag), 0 (dummy), `sign_i`, `result_i[16]` down to `result_i[0]`, then four 0 bits. The first bit is on `sdo_o` once the data phase opens. Each falling edge of the serial clock presents the next bit.
- R5: The 24th rising serial clock edge of a frame starts a new conversion, so `sdo_o` reads 1 if chip select stays low.
- R6: If chip select rises after 1 to 23 rising edges, the frame is dropped and a new conversion starts. The channel bits taken in during that frame are discarded, and `chan_o` keeps its old value.
- R7: If chip select rises after zero rising edges, the block returns to sleep with the captured frame intact, and a later read returns the same frame.
- R8: On the first `CH_W` rising serial clock edges of a frame, `sdi_i` is sampled MSB first. The sampled bits reach `chan_o` on the 24th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host (idle low) |
| sdi_i | input | 1 | Serial data in (channel select) |
| sign_i | input | 1 | 1 when the modelled input is zero or above |
| result_i | input | RES_W | Parallel conversion result |
| sdo_o | output | 1 | Serial data out / end-of-conversion flag |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (0 = high impedance) |
| chan_o | output | CH_W | Channel select latched by the last complete frame |

## Verification
The assertions assume that the serial clock and chip select change slowly next to the system clock. Every level is expected to last several system clocks, so that no edge is lost in the synchronisers, and `sdi_i` is expected to be steady before each rising serial clock edge. The stimulus holds each serial clock phase for six system clocks. It changes the data input only while the serial clock is low, and it waits several clocks after each chip-select change. It holds `sign_i` and `result_i` steady for the whole of each conversion it checks. The one exception is a deliberate change made after a capture.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_DATA} st_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
        s3 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q_o[g]    = s2;
    assign prev_o[g] = s3;
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign done_o = run_q && (cnt_q == CNT_W'(CONV_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_hold_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               load_shift_i,
  input  logic               shift_i,
  output logic               msb_o
);
  logic [FRAME_W-1:0] hold_q, shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      shift_q <= '0;
    end else begin
      if (load_hold_i) hold_q <= frame_i;
      // shifter reloads from hold each data phase so a zero-edge exit keeps data
      if (load_shift_i)  shift_q <= hold_q;
      else if (shift_i)  shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign msb_o = shift_q[FRAME_W-1];
endmodule

// File: rtl/chan_rx.sv
module chan_rx #(
  parameter int CH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sdi_i,
  input  logic            clear_i,
  input  logic            shift_i,
  input  logic            latch_i,
  output logic [CH_W-1:0] chan_o
);
  logic            sdi_m, sdi_s;
  logic [CH_W-1:0] cap_q, chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdi_m  <= 1'b0;
      sdi_s  <= 1'b0;
      cap_q  <= '0;
      chan_q <= '0;
    end else begin
      sdi_m <= sdi_i;
      sdi_s <= sdi_m;
      if (clear_i)      cap_q <= '0;
      else if (shift_i) cap_q <= {cap_q[CH_W-2:0], sdi_s};
      if (latch_i)      chan_q <= cap_q;
    end
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adcsp_pkg::*;
#(
  parameter int CONV_CYCLES = 64,
  parameter int RES_W       = 17,
  parameter int PAD_W       = 4,
  parameter int CH_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             sign_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CH_W-1:0]  chan_o
);
  localparam int FRAME_W = 3 + RES_W + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [1:0] sq, sp;
  logic cs_s, cs_rise, sck_rise, sck_fall;

  sync_edge #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, cs_ni}),
    .q_o    (sq),
    .prev_o (sp)
  );

  assign cs_s     = sq[0];
  assign cs_rise  = sq[0] & ~sp[0];
  assign sck_rise = sq[1] & ~sp[1];
  assign sck_fall = ~sq[1] & sp[1];

  st_e              state_q, state_d;
  logic [CNT_W-1:0] rcnt_q, rcnt_d;
  logic timer_start, timer_done, load_hold, load_shift, chan_clear, chan_latch;
  logic tx_shift, rx_shift, tx_msb;

  always_comb begin
    state_d     = state_q;
    rcnt_d      = rcnt_q;
    timer_start = 1'b0;
    load_hold   = 1'b0;
    load_shift  = 1'b0;
    chan_clear  = 1'b0;
    chan_latch  = 1'b0;
    unique case (state_q)
      ST_CONV: if (timer_done) begin
        state_d   = ST_SLEEP;
        load_hold = 1'b1;
      end
      ST_SLEEP: if (!cs_s) begin
        state_d    = ST_DATA;
        rcnt_d     = '0;
        load_shift = 1'b1;
        chan_clear = 1'b1;
      end
      ST_DATA: begin
        if (cs_rise) begin
          if (rcnt_q == '0) begin
            state_d = ST_SLEEP;
          end else begin
            state_d     = ST_CONV;
            timer_start = 1'b1;
          end
        end else if (sck_rise) begin
          if (rcnt_q == CNT_W'(FRAME_W - 1)) begin
            state_d     = ST_CONV;
            timer_start = 1'b1;
            chan_latch  = 1'b1;
          end else begin
            rcnt_d = rcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CONV;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign tx_shift = (state_q == ST_DATA) && sck_fall && !cs_rise;
  assign rx_shift = (state_q == ST_DATA) && sck_rise && !cs_rise &&
                    (rcnt_q < CNT_W'(CH_W));

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (timer_start),
    .done_o  (timer_done)
  );

  frame_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_hold_i  (load_hold),
    .frame_i      ({2'b00, sign_i, result_i, {PAD_W{1'b0}}}),
    .load_shift_i (load_shift),
    .shift_i      (tx_shift),
    .msb_o        (tx_msb)
  );

  chan_rx #(.CH_W(CH_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sdi_i   (sdi_i),
    .clear_i (chan_clear),
    .shift_i (rx_shift),
    .latch_i (chan_latch),
    .chan_o  (chan_o)
  );

  always_comb begin
    unique case (state_q)
      ST_CONV:  sdo_o = 1'b1;
      ST_SLEEP: sdo_o = 1'b0;
      default:  sdo_o = tx_msb;
    endcase
  end

  assign sdo_oe_o = ~cs_s;
endmodule

// File: rtl/adcsp_chk.sv
module adcsp_chk
  import adcsp_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int CNT_W   = 5,
  parameter int CH_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input st_e              state_i,
  input logic             cs_s_i,
  input logic             sdo_i,
  input logic             oe_i,
  input logic [CH_W-1:0]  chan_i,
  input logic [CNT_W-1:0] rcnt_i
);
  // R1
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |-> !oe_i);
  // R2
  busy_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && state_i == ST_CONV) |-> sdo_i);
  // R7
  sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLEEP) |=> (state_i != ST_CONV));
  // R5
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DATA) |-> (rcnt_i < CNT_W'(FRAME_W)));
  // R8
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_i) |-> ($past(state_i) == ST_DATA && state_i == ST_CONV));
endmodule

bind adc_serial_port adcsp_chk #(
  .FRAME_W (FRAME_W),
  .CNT_W   (CNT_W),
  .CH_W    (CH_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (state_q),
  .cs_s_i  (cs_s),
  .sdo_i   (sdo_o),
  .oe_i    (sdo_oe_o),
  .chan_i  (chan_o),
  .rcnt_i  (rcnt_q)
);

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;
  localparam int CONV = 64;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, sign = 1'b0;
  logic [16:0] res = '0;
  logic sdo, oe;
  logic [7:0] chan;

  int total = 0, bad = 0;
  bit finished = 0;
  logic  exp_q[$];
  string tag_q[$];
  event  smp;

  always #2 clk = ~clk;

  adc_serial_port #(.CONV_CYCLES(CONV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sign_i(sign), .result_i(res), .sdo_o(sdo), .sdo_oe_o(oe), .chan_o(chan)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(input logic s, input logic [16:0] r);
    return {2'b00, s, r, 4'b0000};
  endfunction

  // monitor: pops expected serial bits and compares against sdo
  initial forever begin
    @(smp);
    if (exp_q.size() > 0) check(tag_q.pop_front(), {31'd0, sdo}, {31'd0, exp_q.pop_front()});
  end

  // driver: clocks n bits, pushing expected frame bits to the scoreboard
  task automatic read_bits(input logic [23:0] f, input int n, input logic [7:0] ch);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(f[23-i]);
      tag_q.push_back($sformatf("R4 bit%0d", 23 - i));
      -> smp;
      sdi = (i < 8) ? ch[7-i] : 1'b0;
      clks(1);
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
      clks(HALF);
    end
  endtask

  initial begin
    clks(3);
    rst_n = 1'b1;
    clks(1);
    check("R1 oe reset", {31'd0, oe}, 0);
    check("R1 chan reset", {24'd0, chan}, 0);
    res = 17'h1A5C3; sign = 1'b1;
    cs_n = 1'b0;
    clks(5);
    check("R1 oe low cs", {31'd0, oe}, 1);
    check("R2 busy", {31'd0, sdo}, 1);
    clks(50);
    check("R3 still busy", {31'd0, sdo}, 1);
    clks(14);
    check("R3 eoc low", {31'd0, sdo}, 0);
    res = 17'h00F0F; sign = 1'b0;
    clks(4);
    read_bits(mk(1'b1, 17'h1A5C3), 24, 8'hA5);
    clks(4);
    check("R5 new conv", {31'd0, sdo}, 1);
    check("R8 chan latched", {24'd0, chan}, 8'hA5);
    cs_n = 1'b1;
    clks(5);
    check("R1 oe off", {31'd0, oe}, 0);
    clks(CONV + 20);
    // zero-edge select pulse keeps the waiting frame
    cs_n = 1'b0; clks(8);
    check("R3 sleep eoc", {31'd0, sdo}, 0);
    cs_n = 1'b1; clks(8);
    cs_n = 1'b0; clks(8);
    check("R7 stays ready", {31'd0, sdo}, 0);
    read_bits(mk(1'b0, 17'h00F0F), 24, 8'h3C);
    clks(4);
    check("R8 chan second", {24'd0, chan}, 8'h3C);
    cs_n = 1'b1;
    res = 17'h1FFFF; sign = 1'b1;
    clks(CONV + 20);
    cs_n = 1'b0; clks(8);
    read_bits(mk(1'b1, 17'h1FFFF), 5, 8'hFF);
    cs_n = 1'b1; clks(4);
    cs_n = 1'b0; clks(6);
    check("R6 abort restarts", {31'd0, sdo}, 1);
    check("R6 chan kept", {24'd0, chan}, 8'h3C);
    clks(CONV + 20);
    read_bits(mk(1'b1, 17'h1FFFF), 24, 8'h81);
    clks(4);
    check("R8 chan third", {24'd0, chan}, 8'h81);
    check("R4 queue drained", exp_q.size(), 0);
    cs_n = 1'b1;
    clks(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule